// File: doc/BRIEF.md
# Quasi-Resonant Switching Cycle Controller

This block times each switching cycle of a valley-switching flyback converter. It runs on a single clock and works only from digital comparator flags: the auxiliary-winding demagnetisation flag, the peak-current PWM trip, the cycle-by-cycle current-limit trip, a pair of light-load flags and the overvoltage flag. From these it produces the power-switch gate enable, the sense-capacitor discharge control and a strobe that marks pulses ended by the current limit.

A new on-time starts when the auxiliary winding rings down through its demagnetisation level. The block holds off any turn-on until a minimum off time has passed since the last turn-off. A ring-down seen during that hold-off is remembered and acted on once the hold-off ends. If no ring-down arrives at all, a restart timer forces a pulse. The current comparators are ignored for a blanking window at the start of each pulse, and the sense capacitor is held discharged through that window and through the whole off time. Once per off period the overvoltage flag is sampled after a fixed delay, so that the leakage spike right after turn-off is skipped. A hysteretic light-load state suppresses new pulses. All times are clock-cycle counts set by parameters.

Top module: `qr_cycle_ctrl`

## Requirements
- R1: `aux_hi` is 1 while the auxiliary winding is above the demagnetisation level. If `aux_hi` is 1 at one rising edge and 0 at the next, that is a valley. A valley seen n cycles after the gate fell, with n >= MIN_OFF_CYC, turns the gate on at that edge. The gate is then low for exactly n cycles.
- R2: The gate stays low for at least MIN_OFF_CYC cycles after each turn-off. A valley seen earlier is remembered, and the gate rises after exactly MIN_OFF_CYC low cycles.
- R3: During the first BLANK_CYC cycles of each on-time, `pwm_trip` and `ilim_trip` are ignored and `cs_dis` stays 1. From on-cycle BLANK_CYC+1 onward `cs_dis` is 0. `cs_dis` is 1 whenever the gate is low.
- R4: The pulse ends at the first edge after the blanking window at which `pwm_trip` or `ilim_trip` is 1. A trip first presented in on-cycle d gives a pulse of max(d, BLANK_CYC) cycles. `lim_strobe` is 1 for exactly the first low cycle when `ilim_trip` was high at that edge, and stays 0 when only `pwm_trip` ended the pulse.
- R5: `skip_lo` = 1 enters light-load skip and `skip_hi` = 1 leaves it; `skip_hi` wins when both are set. With both at 0 the state is held. No pulse starts while in skip. When a turn-on is due, the gate rises two cycles after `skip_hi` is presented.
- R6: If no valley arrives, the gate turns on after exactly RESTART_CYC low cycles.
- R7: `ovp_hi` is sampled once per off period, at the edge OVP_DLY_CYC cycles after the gate fell, and is ignored at all other times. No sample is taken after enable until a pulse has ended. A high sample sets `ovp_fault`, which stays set until `rst`.
- R8: With `en` = 0 the gate is low from the next edge, `cs_dis` is 1, and the skip state, the stored valley and all cycle timers are cleared. After `en` returns with a valley, the gate rises between MIN_OFF_CYC-1 and MIN_OFF_CYC+1 cycles later.
- R9: After `rst`, `gate` = 0, `cs_dis` = 1, `lim_strobe` = 0 and `ovp_fault` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Supervisor enable; 0 forces the gate low and clears the timers |
| aux_hi | input | 1 | Auxiliary winding above the demagnetisation level |
| pwm_trip | input | 1 | Peak current has reached the loop demand |
| ilim_trip | input | 1 | Sense voltage above the current limit |
| skip_lo | input | 1 | PWM demand at or below the skip entry level |
| skip_hi | input | 1 | PWM demand above the skip exit level |
| ovp_hi | input | 1 | Overvoltage comparator output |
| gate | output | 1 | Power-switch gate enable |
| cs_dis | output | 1 | Sense-capacitor discharge / blanking control |
| lim_strobe | output | 1 | One-cycle pulse when the current limit ended the pulse |
| ovp_fault | output | 1 | Sticky overvoltage fault flag |

## Verification
The hardest case to reach is a ring-down that arrives while a turn-on is blocked, either by the minimum off time or by skip. Only the stored valley can then start the pulse, and exact cycle counts are needed to tell it apart from the restart timer. The bench lowers `aux_hi` at a chosen off-cycle index, well before the hold-off ends or while skip is held, and checks the low time against MIN_OFF_CYC and not RESTART_CYC. The overvoltage window needs the same precision: the comparator is driven high on every off cycle near the sampling edge except that one, and then on that one alone.

// File: rtl/qr_pkg.sv
package qr_pkg;
  typedef enum logic {PH_OFF = 1'b0, PH_ON = 1'b1} qr_phase_e;
endpackage

// File: rtl/qr_valley_mem.sv
module qr_valley_mem (
  input  logic clk,
  input  logic rst,
  input  logic aux_hi,
  input  logic arm,
  input  logic clr,
  output logic valley_now,
  output logic pend
);
  logic aux_d;

  always_ff @(posedge clk) begin
    if (rst) aux_d <= 1'b0;
    else     aux_d <= aux_hi;
  end

  assign valley_now = aux_d & ~aux_hi;

  // A valley seen while turn-on is blocked is held until used.
  always_ff @(posedge clk) begin
    if (rst || clr)             pend <= 1'b0;
    else if (arm && valley_now) pend <= 1'b1;
  end
endmodule

// File: rtl/qr_skip_hyst.sv
module qr_skip_hyst (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic below_lo,
  input  logic above_hi,
  output logic skip_act
);
  always_ff @(posedge clk) begin
    if (rst || clr)    skip_act <= 1'b0;
    else if (above_hi) skip_act <= 1'b0;
    else if (below_lo) skip_act <= 1'b1;
  end
endmodule

// File: rtl/qr_off_timer.sv
module qr_off_timer #(
  parameter int MIN_OFF = 1538,
  parameter int OVP_DLY = 210,
  parameter int RESTART = 2400
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic min_ok,
  output logic restart_due,
  output logic ovp_tick
);
  localparam int W = $clog2(RESTART + 1);
  localparam logic [W-1:0] MIN_C = W'(MIN_OFF);
  localparam logic [W-1:0] OVP_C = W'(OVP_DLY);
  localparam logic [W-1:0] RST_C = W'(RESTART);

  logic [W-1:0] cnt;

  // cnt equals the number of low cycles elapsed at the edge where it is read.
  always_ff @(posedge clk) begin
    if (rst || load)    cnt <= W'(1);
    else if (cnt < RST_C) cnt <= cnt + W'(1);
  end

  assign min_ok      = (cnt >= MIN_C);
  assign restart_due = (cnt >= RST_C);
  assign ovp_tick    = (cnt == OVP_C);
endmodule

// File: rtl/qr_cycle_ctrl.sv
module qr_cycle_ctrl
  import qr_pkg::*;
#(
  parameter int MIN_OFF_CYC = 1538,
  parameter int BLANK_CYC   = 18,
  parameter int OVP_DLY_CYC = 210,
  parameter int RESTART_CYC = 2400
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic aux_hi,
  input  logic pwm_trip,
  input  logic ilim_trip,
  input  logic skip_lo,
  input  logic skip_hi,
  input  logic ovp_hi,
  output logic gate,
  output logic cs_dis,
  output logic lim_strobe,
  output logic ovp_fault
);
  localparam int ON_W = $clog2(BLANK_CYC + 1);
  localparam logic [ON_W-1:0] BLANK_C = ON_W'(BLANK_CYC);

  qr_phase_e       phase;
  logic [ON_W-1:0] on_cnt;
  logic            ovp_armed;
  logic            valley_now, pend, skip_act;
  logic            min_ok, restart_due, ovp_tick;
  logic            turn_on, turn_off, blank_done;

  assign blank_done = (on_cnt >= BLANK_C);
  assign turn_on    = en && (phase == PH_OFF) && !skip_act &&
                      (restart_due || (min_ok && (valley_now || pend)));
  assign turn_off   = en && (phase == PH_ON) && blank_done &&
                      (pwm_trip || ilim_trip);

  qr_valley_mem u_valley (
    .clk        (clk),
    .rst        (rst),
    .aux_hi     (aux_hi),
    .arm        (en && (phase == PH_OFF)),
    .clr        (!en || turn_on),
    .valley_now (valley_now),
    .pend       (pend)
  );

  qr_skip_hyst u_skip (
    .clk      (clk),
    .rst      (rst),
    .clr      (!en),
    .below_lo (skip_lo),
    .above_hi (skip_hi),
    .skip_act (skip_act)
  );

  qr_off_timer #(
    .MIN_OFF (MIN_OFF_CYC),
    .OVP_DLY (OVP_DLY_CYC),
    .RESTART (RESTART_CYC)
  ) u_timer (
    .clk         (clk),
    .rst         (rst),
    .load        (!en || turn_off),
    .min_ok      (min_ok),
    .restart_due (restart_due),
    .ovp_tick    (ovp_tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_OFF;
      on_cnt     <= '0;
      cs_dis     <= 1'b1;
      lim_strobe <= 1'b0;
      ovp_armed  <= 1'b0;
      ovp_fault  <= 1'b0;
    end else begin
      lim_strobe <= turn_off && ilim_trip;
      if (!en) begin
        phase     <= PH_OFF;
        on_cnt    <= '0;
        cs_dis    <= 1'b1;
        ovp_armed <= 1'b0;
      end else if (turn_on) begin
        phase  <= PH_ON;
        on_cnt <= ON_W'(1);
        cs_dis <= 1'b1;
      end else if (turn_off) begin
        phase     <= PH_OFF;
        cs_dis    <= 1'b1;
        ovp_armed <= 1'b1;
      end else if (phase == PH_ON) begin
        if (!blank_done) on_cnt <= on_cnt + ON_W'(1);
        cs_dis <= (on_cnt < BLANK_C);
      end else begin
        cs_dis <= 1'b1;
        if (ovp_armed && ovp_tick) begin
          ovp_armed <= 1'b0;
          if (ovp_hi) ovp_fault <= 1'b1;
        end
      end
    end
  end

  assign gate = (phase == PH_ON);
endmodule

// File: rtl/qr_cycle_chk.sv
module qr_cycle_chk #(
  parameter int MIN_OFF_CYC = 1538
) (
  input logic clk,
  input logic rst,
  input logic en,
  input logic gate,
  input logic cs_dis,
  input logic lim_strobe,
  input logic ovp_fault,
  input logic skip_act
);
  localparam int LW = $clog2(MIN_OFF_CYC + 1);
  localparam logic [LW-1:0] MIN_C = LW'(MIN_OFF_CYC);

  logic [LW-1:0] low_cnt;
  logic          seen;

  always_ff @(posedge clk) begin
    if (rst || gate)        low_cnt <= '0;
    else if (low_cnt < MIN_C) low_cnt <= low_cnt + LW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) seen <= 1'b0;
    else if (gate)  seen <= 1'b1;
  end

  p_min_off_r2: assert property (@(posedge clk) disable iff (rst)
    ($rose(gate) && seen) |-> (low_cnt >= MIN_C));

  p_blank_dis_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(gate) |-> cs_dis);

  p_off_dis_r3: assert property (@(posedge clk) disable iff (rst)
    !gate |-> cs_dis);

  p_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    lim_strobe |-> (!gate && $past(gate)));

  p_skip_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (skip_act && !gate) |=> !gate);

  p_fault_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    ovp_fault |=> ovp_fault);

  p_disable_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!gate && cs_dis));
endmodule

bind qr_cycle_ctrl qr_cycle_chk #(.MIN_OFF_CYC(MIN_OFF_CYC)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .en         (en),
  .gate       (gate),
  .cs_dis     (cs_dis),
  .lim_strobe (lim_strobe),
  .ovp_fault  (ovp_fault),
  .skip_act   (skip_act)
);

// File: tb/tb_qr_cycle_ctrl.sv
module tb_qr_cycle_ctrl;
  localparam int MIN_OFF = 20;
  localparam int BLANK   = 4;
  localparam int OVP_DLY = 6;
  localparam int RESTART = 40;
  localparam int NVEC    = 5;
  // trip on-cycle, use current limit, expected width, valley off-cycle
  localparam int VEC [0:NVEC-1][0:3] = '{
    '{1, 0, 4, 25},
    '{3, 1, 4, 22},
    '{4, 0, 4, 30},
    '{5, 1, 5, 20},
    '{9, 0, 9, 38}
  };

  logic clk = 1'b0;
  logic rst = 1'b1, en = 1'b1, aux_hi = 1'b0, pwm_trip = 1'b0, ilim_trip = 1'b0;
  logic skip_lo = 1'b0, skip_hi = 1'b0, ovp_hi = 1'b0;
  logic gate, cs_dis, lim_strobe, ovp_fault;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  qr_cycle_ctrl #(
    .MIN_OFF_CYC(MIN_OFF), .BLANK_CYC(BLANK),
    .OVP_DLY_CYC(OVP_DLY), .RESTART_CYC(RESTART)
  ) dut (
    .clk(clk), .rst(rst), .en(en), .aux_hi(aux_hi), .pwm_trip(pwm_trip),
    .ilim_trip(ilim_trip), .skip_lo(skip_lo), .skip_hi(skip_hi), .ovp_hi(ovp_hi),
    .gate(gate), .cs_dis(cs_dis), .lim_strobe(lim_strobe), .ovp_fault(ovp_fault)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called on the first high sample of a pulse; returns on its first low sample.
  task automatic run_on(input int d, input bit lim, input int exp_w);
    int w = 1;
    chk("R3 cs_dis in first on-cycle", cs_dis, 1);
    while (1) begin
      if (w == d) begin
        if (lim) ilim_trip = 1'b1;
        else     pwm_trip  = 1'b1;
      end
      @(negedge clk);
      if (!gate) break;
      w++;
      if (w == BLANK + 1) chk("R3 cs_dis low after blanking", cs_dis, 0);
    end
    chk("R4 pulse width", w, exp_w);
    chk("R4 limit strobe", lim_strobe, int'(lim));
    pwm_trip  = 1'b0;
    ilim_trip = 1'b0;
  endtask

  // Called on the first low sample; returns the low cycle count.
  task automatic off_phase(input int act_at, input int lim, input int mode, output int n);
    n = 1;
    aux_hi = 1'b1;
    while (1) begin
      if (n == act_at) aux_hi = 1'b0;
      ovp_hi = (mode == 1) ? (n != OVP_DLY && n <= OVP_DLY + 3) :
               (mode == 2) ? (n == OVP_DLY) : 1'b0;
      @(negedge clk);
      if (gate) break;
      n++;
      if (n > lim) break;
    end
    ovp_hi = 1'b0;
  endtask

  initial begin
    int n;
    int gate_seen;
    repeat (4) @(negedge clk);
    chk("R9 gate after reset", gate, 0);
    chk("R9 cs_dis after reset", cs_dis, 1);
    chk("R9 strobe after reset", lim_strobe, 0);
    chk("R9 fault after reset", ovp_fault, 0);
    rst = 1'b0;
    n = 0;
    while (!gate && n < RESTART + 5) begin
      @(negedge clk);
      n++;
    end
    chk("R6 first pulse from restart timer", gate, 1);

    for (int i = 0; i < NVEC; i++) begin
      run_on(VEC[i][0], VEC[i][1] != 0, VEC[i][2]);
      off_phase(VEC[i][3], 100, 0, n);
      chk("R1 valley turn-on low time", n, VEC[i][3]);
    end

    run_on(5, 1'b0, 5);
    off_phase(5, 100, 0, n);
    chk("R2 early valley held to min off", n, MIN_OFF);

    run_on(6, 1'b1, 6);
    off_phase(0, 100, 0, n);
    chk("R6 restart with no valley", n, RESTART);

    run_on(5, 1'b0, 5);
    off_phase(25, 100, 1, n);
    chk("R7 ovp outside window ignored", ovp_fault, 0);
    chk("R1 valley after ovp spikes", n, 25);

    run_on(5, 1'b0, 5);
    off_phase(25, 100, 2, n);
    chk("R7 ovp sampled at delay", ovp_fault, 1);

    run_on(5, 1'b0, 5);
    skip_lo = 1'b1;
    aux_hi  = 1'b1;
    n = 1;
    gate_seen = 0;
    while (n < 80) begin
      if (n == 3)  skip_lo = 1'b0;
      if (n == 25) aux_hi  = 1'b0;
      @(negedge clk);
      if (gate) gate_seen = 1;
      n++;
    end
    chk("R5 no pulse while skipping", gate_seen, 0);
    chk("R7 fault stays set", ovp_fault, 1);
    skip_hi = 1'b1;
    @(negedge clk);
    skip_hi = 1'b0;
    chk("R5 gate one cycle after exit", gate, 0);
    @(negedge clk);
    chk("R5 gate two cycles after exit", gate, 1);

    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk("R8 gate low after disable", gate, 0);
    chk("R8 cs_dis after disable", cs_dis, 1);
    aux_hi = 1'b1;
    repeat (2) @(negedge clk);
    en = 1'b1;
    aux_hi = 1'b0;
    n = 0;
    while (n < 100) begin
      @(negedge clk);
      if (gate) break;
      n++;
    end
    chk("R8 hold-off after re-enable", int'(n >= MIN_OFF - 1 && n <= MIN_OFF + 1), 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule